// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Audio Playback Buffer

This block holds 1024 signed or unsigned 16-bit audio samples in a 2 KiB two-port memory. A producer in a fast clock domain loads it a byte at a time. A playback engine on the slow sample clock, at about 48 kHz, reads one sample per cycle and presents it on a 16-bit output. The engine is controlled by play and stop inputs and by a two-bit speed code. The speed code can hold the read position, step one sample per cycle or step two samples per cycle.

The block reports whether playback is running. It also reports which half of the sample space the read pointer is in. A producer watches that half flag and rewrites the half that is not being played. Because the read pointer wraps from the last sample to the first, the two halves alternate for as long as playback runs. This gives continuous double-buffered audio.

Top module: `pingpong_audio_buf`

## Requirements
- R1: A synchronous active-high reset on the sample clock clears `playing_o`, sets the read position to sample 0 (so `upper_half_o` is 0) and sets `sample_o` to 0.
- R2: A write with `wr_en_i` high stores `wr_data_i` on a rising edge of `wr_clk`. Bit 0 of `wr_addr_i` selects the byte lane: 0 is the low byte and 1 is the high byte. Bits 10:1 give the sample index n, so sample n sits at byte addresses 2n and 2n+1.
- R3: When `play_i` is high and `stop_i` is low at a sample-clock edge, `playing_o` is high after that edge.
- R4: Reads have one cycle of latency. While playing, each edge loads `sample_o` with the sample at the read position held before that edge. The first sample therefore appears one cycle after `playing_o` rises.
- R5: While playing, each edge advances the read position by a step set by `speed_i`: code 0 adds 0 (pause), code 1 adds 1, code 2 adds 2, and code 3 adds 1.
- R6: The read position is taken modulo 1024, so it wraps from sample 1023 to sample 0.
- R7: `upper_half_o` is 1 exactly when the current read position is in 512..1023.
- R8: When `stop_i` is high at an edge, `playing_o` is low after it. This holds even if `play_i` is high in the same cycle.
- R9: While not playing, the read position and `sample_o` hold their values. A later play resumes reading from the held position.
- R10: Writes to the half that is not being read do not disturb playback. The new data is played on the next pass through that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sample clock (read domain) |
| smp_rst | input | 1 | Synchronous active-high reset, sample domain |
| play_i | input | 1 | Start or resume playback |
| stop_i | input | 1 | Halt playback, has priority over play |
| speed_i | input | 2 | Step code: 0 pause, 1 one, 2 two, 3 one |
| playing_o | output | 1 | Playback running |
| upper_half_o | output | 1 | Read position is in the upper half |
| sample_o | output | 16 | Current output sample |
| wr_clk | input | 1 | Writer clock |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 11 | Byte address |
| wr_data_i | input | 8 | Byte to store |

## Verification
The assertions assume that `play_i`, `stop_i` and `speed_i` are synchronous to the sample clock. They also assume that reset is asserted for at least one sample edge before anything else happens. The hold and wrap checks take for granted that the producer never writes a byte of the sample being read in the same window. Reads and writes are not compared across the clock boundary.

The stimulus changes controls only at falling sample-clock edges and fills the whole memory only while playback is stopped. During the ping-pong scenario it rewrites the lower half only after `upper_half_o` rises, and the writer finishes long before the pointer wraps back.

// File: rtl/pab_pkg.sv
package pab_pkg;

    typedef enum logic [1:0] {
        SPD_HOLD   = 2'd0,
        SPD_SINGLE = 2'd1,
        SPD_DOUBLE = 2'd2,
        SPD_SPARE  = 2'd3
    } speed_e;

    // Read-pointer increment for a speed code; the spare code steps by one.
    function automatic logic [1:0] step_of(logic [1:0] code);
        logic [1:0] s;
        case (speed_e'(code))
            SPD_HOLD:   s = 2'd0;
            SPD_DOUBLE: s = 2'd2;
            default:    s = 2'd1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pab_byte_bank.sv
module pab_byte_bank #(
    parameter int DEPTH  = 1024,
    parameter int BYTE_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rd_d, rd_q;

    always_ff @(posedge wr_clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = mem[rd_addr];
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    // R1: the output register comes out of reset at zero
    p_out_reset_r1: assert property (@(posedge rd_clk)
        rd_rst |=> (rd_q == '0));

    // R9: with no read issued, the byte output keeps its value
    p_out_hold_r9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/pab_read_ctrl.sv
module pab_read_ctrl #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          play,
    input  logic          stop,
    input  logic [1:0]    speed,
    output logic          playing,
    output logic [AW-1:0] rd_addr
);

    import pab_pkg::*;

    typedef struct packed {
        logic          playing;
        logic [AW-1:0] addr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.playing) begin
            st_d.addr = st_q.addr + AW'(step_of(speed));
        end
        if (stop) begin
            st_d.playing = 1'b0;
        end else if (play) begin
            st_d.playing = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign playing = st_q.playing;
    assign rd_addr = st_q.addr;

    // R1: reset leaves the engine idle at sample 0
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!st_q.playing && st_q.addr == '0));

    // R3: an uncontested play starts playback on the next edge
    p_play_starts_r3: assert property (@(posedge clk) disable iff (rst)
        (play && !stop) |=> st_q.playing);

    // R8: stop always wins
    p_stop_wins_r8: assert property (@(posedge clk) disable iff (rst)
        stop |=> !st_q.playing);

    // R9: the read position is frozen while idle
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !st_q.playing |=> $stable(st_q.addr));

    // R5: pause code keeps the position even while playing
    p_pause_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (speed == 2'd0) |=> $stable(st_q.addr));

    // R6: single-step from the last sample lands on sample 0
    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.playing && speed == 2'd1 && st_q.addr == '1) |=> (st_q.addr == '0));

endmodule

// File: rtl/pingpong_audio_buf.sv
module pingpong_audio_buf #(
    parameter int SAMPLES  = 1024,
    parameter int SAMPLE_W = 16,
    parameter int BYTE_W   = 8,
    localparam int LANES   = SAMPLE_W / BYTE_W,
    localparam int LANE_W  = $clog2(LANES),
    localparam int SAW     = $clog2(SAMPLES),
    localparam int BAW     = SAW + LANE_W
) (
    input  logic                smp_clk,
    input  logic                smp_rst,
    input  logic                play_i,
    input  logic                stop_i,
    input  logic [1:0]          speed_i,
    output logic                playing_o,
    output logic                upper_half_o,
    output logic [SAMPLE_W-1:0] sample_o,
    input  logic                wr_clk,
    input  logic                wr_en_i,
    input  logic [BAW-1:0]      wr_addr_i,
    input  logic [BYTE_W-1:0]   wr_data_i
);

    logic           playing;
    logic [SAW-1:0] rd_addr;

    pab_read_ctrl #(.DEPTH(SAMPLES)) i_ctrl (
        .clk     (smp_clk),
        .rst     (smp_rst),
        .play    (play_i),
        .stop    (stop_i),
        .speed   (speed_i),
        .playing (playing),
        .rd_addr (rd_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic              lane_we;
        logic [BYTE_W-1:0] lane_q;

        assign lane_we = wr_en_i && (wr_addr_i[LANE_W-1:0] == LANE_W'(g));

        pab_byte_bank #(.DEPTH(SAMPLES), .BYTE_W(BYTE_W)) i_bank (
            .wr_clk  (wr_clk),
            .wr_en   (lane_we),
            .wr_addr (wr_addr_i[BAW-1:LANE_W]),
            .wr_data (wr_data_i),
            .rd_clk  (smp_clk),
            .rd_rst  (smp_rst),
            .rd_en   (playing),
            .rd_addr (rd_addr),
            .rd_data (lane_q)
        );

        assign sample_o[g*BYTE_W +: BYTE_W] = lane_q;
    end

    assign playing_o    = playing;
    assign upper_half_o = rd_addr[SAW-1];

    // R7: the half flag only changes on a playing edge
    p_half_stable_r7: assert property (@(posedge smp_clk) disable iff (smp_rst)
        !playing_o |=> $stable(upper_half_o));

    // R9: the output sample is held while idle
    p_sample_hold_r9: assert property (@(posedge smp_clk) disable iff (smp_rst)
        !playing_o |=> $stable(sample_o));

endmodule

// File: tb/test_pingpong_audio_buf.sv
module test_pingpong_audio_buf;

    logic        smp_clk = 1'b0;
    logic        smp_rst = 1'b1;
    logic        play_i = 1'b0, stop_i = 1'b0;
    logic [1:0]  speed_i = 2'd1;
    logic        playing_o, upper_half_o;
    logic [15:0] sample_o;
    logic        wr_clk = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [10:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    // bench reference state
    logic [15:0] ref_mem [1024];
    logic        m_play = 1'b0;
    logic [9:0]  m_addr = '0;
    logic [15:0] m_smp = '0;

    always #4 smp_clk = ~smp_clk;   // 125 MHz
    always #1 wr_clk  = ~wr_clk;    // faster writer

    pingpong_audio_buf i_pingpong_audio_buf (
        .smp_clk, .smp_rst, .play_i, .stop_i, .speed_i,
        .playing_o, .upper_half_o, .sample_o,
        .wr_clk, .wr_en_i, .wr_addr_i, .wr_data_i
    );

    function automatic logic [15:0] pat(int n, logic [15:0] seed);
        return 16'(n * 40503) ^ seed;
    endfunction

    function automatic logic [9:0] step_ref(logic [1:0] c);
        return (c == 2'd0) ? 10'd0 : (c == 2'd2) ? 10'd2 : 10'd1;
    endfunction

    always @(posedge smp_clk) begin
        if (smp_rst) begin
            m_play = 1'b0; m_addr = '0; m_smp = '0;
        end else begin
            if (m_play) begin
                m_smp  = ref_mem[m_addr];
                m_addr = m_addr + step_ref(speed_i);
            end
            m_play = stop_i ? 1'b0 : (play_i ? 1'b1 : m_play);
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // one sample cycle, then compare all outputs to the reference
    task automatic cyc(string tag);
        @(negedge smp_clk);
        check({tag, " playing"}, 32'(playing_o), 32'(m_play));
        check({tag, " R7 half"}, 32'(upper_half_o), 32'(m_addr[9]));
        check({tag, " sample"}, 32'(sample_o), 32'(m_smp));
    endtask

    task automatic wr_byte(int a, logic [7:0] d);
        @(negedge wr_clk);
        wr_en_i = 1'b1; wr_addr_i = 11'(a); wr_data_i = d;
        @(posedge wr_clk);
        if (a[0]) ref_mem[a >> 1][15:8] = d;
        else      ref_mem[a >> 1][7:0]  = d;
        @(negedge wr_clk);
        wr_en_i = 1'b0;
    endtask

    task automatic fill(int first, int count, logic [15:0] seed);
        for (int i = first; i < first + count; i++) begin
            wr_byte(2 * i + 1, pat(i, seed) >> 8);   // high lane first
            wr_byte(2 * i, pat(i, seed) & 16'hff);
        end
    endtask

    task automatic t_reset();
        smp_rst = 1'b1; play_i = 0; stop_i = 0;
        @(negedge smp_clk); @(negedge smp_clk);
        smp_rst = 1'b0;
        check("R1 playing after reset", 32'(playing_o), 0);
        check("R1 half after reset", 32'(upper_half_o), 0);
        check("R1 sample after reset", 32'(sample_o), 0);
    endtask

    task automatic t_linear(logic [15:0] seed);
        speed_i = 2'd1; play_i = 1'b1;
        @(negedge smp_clk);
        play_i = 1'b0;
        check("R3 playing one edge after play", 32'(playing_o), 1);
        @(negedge smp_clk);
        check("R4 R2 first sample", 32'(sample_o), 32'(pat(0, seed)));
        @(negedge smp_clk);
        check("R4 second sample", 32'(sample_o), 32'(pat(1, seed)));
        for (int k = 0; k < 520; k++) cyc("R4 linear");
        check("R7 upper half reached", 32'(upper_half_o), 1);
        for (int k = 0; k < 520; k++) cyc("R6 wrap pass");
        check("R6 back in lower half", 32'(upper_half_o), 0);
    endtask

    task automatic t_stop_hold();
        logic [15:0] held;
        stop_i = 1'b1;
        cyc("R8 stop");
        stop_i = 1'b0;
        check("R8 playing cleared", 32'(playing_o), 0);
        cyc("R9 idle");
        held = sample_o;
        for (int k = 0; k < 20; k++) cyc("R9 idle");
        check("R9 sample held", 32'(sample_o), 32'(held));
        play_i = 1'b1; stop_i = 1'b1;
        cyc("R8 play and stop together");
        check("R8 stop wins", 32'(playing_o), 0);
        stop_i = 1'b0;
        cyc("R9 resume");
        play_i = 1'b0;
        for (int k = 0; k < 10; k++) cyc("R9 resume continues");
    endtask

    task automatic t_speed();
        logic [15:0] held;
        speed_i = 2'd2;
        for (int k = 0; k < 40; k++) cyc("R5 double step");
        speed_i = 2'd0;
        cyc("R5 pause");
        cyc("R5 pause");
        held = sample_o;
        for (int k = 0; k < 10; k++) cyc("R5 pause");
        check("R5 paused sample constant", 32'(sample_o), 32'(held));
        check("R5 still playing while paused", 32'(playing_o), 1);
        speed_i = 2'd3;
        for (int k = 0; k < 20; k++) cyc("R5 spare code");
        speed_i = 2'd1;
    endtask

    task automatic t_pingpong(logic [15:0] seed_b);
        t_reset();
        t_linear_start();
        fork
            for (int k = 0; k < 1300; k++) cyc("R10 pingpong");
            begin
                wait (upper_half_o == 1'b1);
                fill(0, 512, seed_b);
            end
        join
    endtask

    task automatic t_linear_start();
        speed_i = 2'd1; play_i = 1'b1;
        cyc("R3 start");
        play_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 1024; i++) ref_mem[i] = 'x;
        t_reset();
        fill(0, 1024, 16'h5a3c);
        t_linear(16'h5a3c);
        t_stop_hold();
        t_speed();
        t_pingpong(16'hc3a1);
        check("R10 lower half rewritten", 32'(ref_mem[7]), 32'(pat(7, 16'hc3a1)));
        summary();
    end

endmodule